// File: doc/BRIEF.md
# Multicast Contention Resolution Unit

This block sits in an input port controller of a multicast switch. Each output group returns a serial feedback priority. That value is the priority of the cell that won that group in the current cell cycle. The block deserializes each feedback stream into a 16-bit word and compares it with the local priority of the head-of-line cell. A smaller value means a higher priority. Every group where the feedback value is greater than or equal to the local value counts as reached, and its bit is removed from the cell's multicast pattern.

When the comparisons finish, the block presents the reduced pattern and a resend flag. The flag is high when any group is still unreached. The cell is then sent again in the next cell cycle, carrying the reduced pattern, so it retries only the groups it missed. The parameter `SHARED` selects the hardware variant. With `SHARED` = 0, K comparator lanes work in parallel. With `SHARED` = 1, one comparator is stepped across the K registered feedback words, one word per clock.

Top module: `mcast_resolver`

## Requirements
- R1: While `bit_en` is high, each lane j shifts `fb_bit[j]` into its own PW-bit deserializer on every clock, most significant bit first. After PW shifted bits, the first bit shifted in is bit PW-1 of the word.
- R2: On a clock edge where `word_ld` is high and the block is idle, the block captures all K deserialized words, `lp` and `pat_in`. This is the accepting edge.
- R3: Bit j of the result is cleared when feedback word j is greater than or equal to `lp`, compared as unsigned values. Bit j keeps its input value when feedback word j is less than `lp`. Bit j of `pat_in` and `pat_out` belongs to output group j, which is fed by `fb_bit[j]`.
- R4: A pattern bit that is 0 at capture stays 0 in the result, whatever its feedback word is.
- R5: When `done` is high, `resend` is 1 exactly when at least one bit of `pat_out` is 1. An all-zero result gives `resend` = 0.
- R6: `done` rises one clock after the accepting edge when `SHARED` = 0, and K clocks after it when `SHARED` = 1. `pat_out` and `resend` change in that same cycle.
- R7: `done` is high for a single cycle per accepted load. `pat_out` and `resend` hold their value in every cycle where `done` is low.
- R8: `word_ld` is ignored while a comparison is in progress. A load strobe that arrives then changes neither the result nor the number of `done` pulses.
- R9: While `rst_n` is low, `pat_out`, `resend` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit and cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Shift enable for all deserializers |
| fb_bit | input | K | One serial feedback priority bit per output group |
| word_ld | input | 1 | Word boundary strobe; starts a comparison |
| lp | input | PW | Local priority of the head-of-line cell |
| pat_in | input | K | Multicast pattern of the head-of-line cell |
| pat_out | output | K | Pattern left after clearing reached groups |
| resend | output | 1 | At least one group still unreached |
| done | output | 1 | One-cycle pulse when `pat_out` and `resend` are updated |

## Verification
The hardest case to reach from the ports is a load strobe that arrives while the time-shared comparator is part way through its K steps. In the parallel variant the same strobe must land exactly on the single busy edge. The bench reaches it by asserting `word_ld` a second time on the clock right after an accepted load. That second load carries a local priority of zero and a full pattern, which would clear every bit if it were accepted. The bench then checks that the result and the done count still match the first load. The vector values are chosen to be asymmetric in their high and low bytes, and several have feedback equal to the local priority, so a wrong shift order or an off-by-one compare shows up in `pat_out`.

// File: rtl/mcast_resolver.sv
module mcast_resolver #(
  parameter int K      = 16,
  parameter int PW     = 16,
  parameter bit SHARED = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic [K-1:0]  fb_bit,
  input  logic          word_ld,
  input  logic [PW-1:0] lp,
  input  logic [K-1:0]  pat_in,
  output logic [K-1:0]  pat_out,
  output logic          resend,
  output logic          done
);
  localparam int IW = (K > 1) ? $clog2(K) : 1;

  logic [K-1:0][PW-1:0] sh_q, fb_q;
  logic [PW-1:0]        lp_q;
  logic [K-1:0]         work_q, clr, next_pat;
  logic [IW-1:0]        idx_q;
  logic                 busy_q, last;

  for (genvar j = 0; j < K; j++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      sh_q[j] <= '0;
      else if (bit_en) sh_q[j] <= {sh_q[j][PW-2:0], fb_bit[j]};
  end

  if (SHARED) begin : g_tdm
    logic [PW-1:0] fb_sel;
    assign fb_sel = fb_q[idx_q];
    assign clr    = (fb_sel >= lp_q) ? (K'(1) << idx_q) : '0;
    assign last   = (idx_q == IW'(K-1));
  end else begin : g_par
    for (genvar j = 0; j < K; j++) begin : g_cmp
      assign clr[j] = (fb_q[j] >= lp_q);
    end
    assign last = 1'b1;
  end

  assign next_pat = work_q & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q    <= '0;
      lp_q    <= '0;
      work_q  <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      pat_out <= '0;
      resend  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (word_ld && !busy_q) begin
        fb_q   <= sh_q;
        lp_q   <= lp;
        work_q <= pat_in;
        idx_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        work_q <= next_pat;
        idx_q  <= idx_q + 1'b1;
        if (last) begin
          busy_q  <= 1'b0;
          pat_out <= next_pat;
          resend  <= |next_pat;
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mcast_resolver_chk.sv
module mcast_resolver_chk #(
  parameter int K   = 16,
  parameter int LAT = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         word_ld,
  input logic [K-1:0] pat_in,
  input logic [K-1:0] pat_out,
  input logic         resend,
  input logic         done
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;
  logic [K-1:0]  cap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      cap <= '0;
    end else if (word_ld && cnt == '0) begin
      cnt <= CW'(LAT);
      cap <= pat_in;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end

  p_done_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == CW'(1) |=> done);
  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cnt) == CW'(1));
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({pat_out, resend}));
  p_resend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> resend == (|pat_out));
  p_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pat_out & ~cap) == '0);
endmodule

bind mcast_resolver mcast_resolver_chk #(.K(K), .LAT(SHARED ? K : 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_ld(word_ld), .pat_in(pat_in),
  .pat_out(pat_out), .resend(resend), .done(done)
);

// File: tb/mcast_resolver_bench.sv
module mcast_resolver_bench;
  localparam int CLK_P = 10;
  localparam int K  = 4;
  localparam int PW = 16;
  localparam int NV = 7;

  typedef struct packed {
    logic [PW-1:0]   lp;
    logic [K*PW-1:0] fb;
    logic [K-1:0]    pat;
    logic [K-1:0]    exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'h0100, {16'h0200, 16'h0100, 16'h00FF, 16'hFFFF}, 4'b1111, 4'b0010},
    '{16'h8000, {16'h0001, 16'h0001, 16'h0001, 16'h0001}, 4'b1111, 4'b1111},
    '{16'h0000, {16'h1234, 16'h0000, 16'h0005, 16'h0007}, 4'b1010, 4'b0000},
    '{16'hFFFF, {16'hFFFF, 16'hFFFE, 16'hFFFF, 16'h0000}, 4'b0110, 4'b0100},
    '{16'h0010, {16'h0000, 16'h0000, 16'h0000, 16'h0000}, 4'b0000, 4'b0000},
    '{16'h0040, {16'h003F, 16'h0041, 16'h0040, 16'h0001}, 4'b1001, 4'b1001},
    '{16'h0800, {16'h0801, 16'h07FF, 16'h0800, 16'h1000}, 4'b1111, 4'b0100}
  };

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, word_ld = 1'b0;
  logic [K-1:0]  fb_bit = '0, pat_in = '0;
  logic [PW-1:0] lp = '0;
  logic [K-1:0]  pat_p, pat_t;
  logic          rs_p, rs_t, dn_p, dn_t;
  int checks = 0, fails = 0, dcnt_p = 0, dcnt_t = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  mcast_resolver #(.K(K), .PW(PW), .SHARED(1'b0)) u_mcast_resolver (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fb_bit(fb_bit), .word_ld(word_ld),
    .lp(lp), .pat_in(pat_in), .pat_out(pat_p), .resend(rs_p), .done(dn_p));

  mcast_resolver #(.K(K), .PW(PW), .SHARED(1'b1)) u_mcast_resolver_tdm (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fb_bit(fb_bit), .word_ld(word_ld),
    .lp(lp), .pat_in(pat_in), .pat_out(pat_t), .resend(rs_t), .done(dn_t));

  always @(posedge clk) begin
    cyc++;
    if (dn_p) dcnt_p++;
    if (dn_t) dcnt_t++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R6 watchdog expired: actual %0d cycles, expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [K*PW-1:0] fbs);
    for (int b = PW-1; b >= 0; b--) begin
      for (int j = 0; j < K; j++) fb_bit[j] = fbs[j*PW + b];
      bit_en = 1'b1;
      @(negedge clk);
    end
    bit_en = 1'b0;
  endtask

  task automatic pulse_ld(input logic [PW-1:0] l, input logic [K-1:0] p);
    lp = l; pat_in = p; word_ld = 1'b1;
    @(negedge clk);
    word_ld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 pat_out par", 32'(pat_p), 0);
    check("R9 resend/done par", {rs_p, dn_p}, 0);
    check("R9 pat_out tdm", 32'(pat_t), 0);
    check("R9 resend/done tdm", {rs_t, dn_t}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5: vector table, both variants
    for (int v = 0; v < NV; v++) begin
      int p0, t0;
      p0 = dcnt_p; t0 = dcnt_t;
      shift_word(VECS[v].fb);
      pulse_ld(VECS[v].lp, VECS[v].pat);
      repeat (K + 2) @(negedge clk);
      check("R3 pat_out par", 32'(pat_p), 32'(VECS[v].exp));
      check("R3 pat_out tdm", 32'(pat_t), 32'(VECS[v].exp));
      check("R5 resend par", 32'(rs_p), 32'(|VECS[v].exp));
      check("R5 resend tdm", 32'(rs_t), 32'(|VECS[v].exp));
      check("R7 one done par", dcnt_p - p0, 1);
      check("R7 one done tdm", dcnt_t - t0, 1);
    end

    // R6: done latency for each variant
    shift_word(VECS[0].fb);
    lp = VECS[0].lp; pat_in = VECS[0].pat; word_ld = 1'b1;
    @(posedge clk); #1;
    word_ld = 1'b0;
    check("R6 no done at accept par", 32'(dn_p), 0);
    @(posedge clk); #1;
    check("R6 done after 1 clk par", 32'(dn_p), 1);
    check("R6 tdm not yet done", 32'(dn_t), 0);
    repeat (K - 2) @(posedge clk);
    #1;
    check("R6 tdm not done at K-1", 32'(dn_t), 0);
    @(posedge clk); #1;
    check("R6 tdm done after K clks", 32'(dn_t), 1);
    check("R6 tdm pattern", 32'(pat_t), 32'(VECS[0].exp));
    @(posedge clk); #1;
    check("R7 done single cycle", {dn_p, dn_t}, 0);
    @(negedge clk);

    // R8: a second strobe while busy is ignored
    begin
      int p0, t0;
      p0 = dcnt_p; t0 = dcnt_t;
      shift_word(VECS[5].fb);
      pulse_ld(VECS[5].lp, VECS[5].pat);
      pulse_ld(16'h0000, 4'b1111);
      repeat (K + 2) @(negedge clk);
      check("R8 ignored ld par", 32'(pat_p), 32'(VECS[5].exp));
      check("R8 ignored ld tdm", 32'(pat_t), 32'(VECS[5].exp));
      check("R8 done count par", dcnt_p - p0, 1);
      check("R8 done count tdm", dcnt_t - t0, 1);
    end

    // R7: outputs hold while idle with input noise
    lp = 16'h0000; pat_in = 4'b1111;
    shift_word(64'h0);
    check("R7 hold par", 32'(pat_p), 32'(VECS[5].exp));
    check("R7 hold tdm", 32'(pat_t), 32'(VECS[5].exp));

    // R9: reset mid-operation clears outputs
    rst_n = 1'b0;
    #1;
    check("R9 async reset", {pat_p, rs_p, dn_p, pat_t, rs_t, dn_t}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule